// File: doc/BRIEF.md
# Monitor ADC Control Register Bank

This block is the register side of a slow-control monitoring converter. A host reaches it through a byte-wide, 3-bit-addressed register port. Through that port the host picks one of eight analog inputs and a converter mode, launches a 12-bit acquisition, and polls an idle flag. Once the acquisition is over, the host reads the result as two bytes. The bank talks to the converter through a one-cycle start pulse and a one-cycle done pulse that carries the 12-bit sample. A fixed 24-bit serial number can be read from three further addresses.

The control state is kept in three copies and voted bit by bit. The voted value is written back to all three copies on every cycle, so an upset in one copy is repaired on the next edge. Any disagreement between the copies sets a sticky error flag that the host can read. The `upset` input lets a test flip one copy on purpose. Reads are combinational from the address. Writes take effect at the clock edge on which `reg_wr` is high.

Top module: `adc_regbank`

## Requirements
- R1: While `rst_n` is low at a clock edge, the bank resets. Afterwards address 0 reads 0x00, address 1 reads 0x80 (idle set, error clear, high nibble 0), address 3 reads 0x00 and `adc_start` is low.
- R2: A write to address 0 loads bits [2:0] as the channel and bit 3 as the mode. These drive `adc_chan` and `adc_mode`. A read of address 0 returns the channel and mode, with bits [7:4] read as zero.
- R3: A write to address 0 with bit 7 set and bit 6 clear, made while idle, starts an acquisition. `adc_start` is high for exactly the one cycle after the write edge, and status bit 7 (idle) reads 0 from that cycle on.
- R4: A start written while an acquisition is in progress produces no `adc_start` pulse.
- R5: An `adc_done` pulse during an acquisition sets idle again one cycle later. On that same edge it loads result bits [11:8] into status bits [3:0] and result bits [7:0] into address 3. A done pulse while idle changes nothing.
- R6: A write to address 0 with bit 6 set clears the channel, mode, acquisition, error flag and both result fields. Any start bit in the same write is ignored.
- R7: Address 5 returns serial bits [7:0], address 6 returns bits [15:8], and address 7 returns bits [23:16].
- R8: Addresses 2 and 4 always read 0x00. Writes to them leave every other register unchanged.
- R9: An upset in one copy of the control state leaves the voted control values unchanged. It sets status bit 6 (error) within two edges, and the flag stays set through later ordinary writes.
- R10: The sticky error flag is cleared only by a soft reset (R6) or by `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| adc_start | output | 1 | One-cycle acquisition launch |
| adc_chan | output | 3 | Selected input channel |
| adc_mode | output | 1 | Selected converter mode |
| adc_done | input | 1 | One-cycle end of acquisition |
| adc_result | input | 12 | Sample, valid while `adc_done` is high |
| upset | input | 3 | Flips every bit of the matching copy of the control state at the next edge |

## Verification
Each result is due a set number of edges after its stimulus:
- The start pulse, the drop of the idle flag and new channel or mode values appear in the cycle right after the write edge.
- The result bytes and the return of idle appear one edge after the done pulse.
- The error flag appears two edges after an injected upset: one edge stores the bad copy, the next records the disagreement.

Inputs are driven on the falling edge. Each check is sampled on the falling edge that follows the edge on which the result is due, so no check depends on the ordering of processes at the rising edge.

// File: rtl/adc_regbank_pkg.sv
// Package: shared widths, register addresses, field positions and the
// layout of the triplicated control state for the monitor ADC bank.
// Assumes an 8-bit register port and a 3-bit register address.
package adc_regbank_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int CHAN_W   = 3;
    localparam int RES_W    = 12;
    localparam int RES_HI_W = RES_W - DATA_W;
    localparam int NCOPY    = 3;
    localparam int ID_W     = 3 * DATA_W;

    // Register addresses (the host decodes these)
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_RSV0  = 3'd2;
    localparam logic [ADDR_W-1:0] A_RESLO = 3'd3;
    localparam logic [ADDR_W-1:0] A_RSV1  = 3'd4;
    localparam logic [ADDR_W-1:0] A_ID0   = 3'd5;
    localparam logic [ADDR_W-1:0] A_ID1   = 3'd6;
    localparam logic [ADDR_W-1:0] A_ID2   = 3'd7;

    // Bit positions inside the control and status bytes
    localparam int B_MODE  = 3;
    localparam int B_SRST  = 6;
    localparam int B_START = 7;
    localparam int B_ERR   = 6;
    localparam int B_IDLE  = 7;

    // Control state held in three voted copies
    typedef struct packed {
        logic              err;
        logic              busy;
        logic              mode;
        logic [CHAN_W-1:0] chan;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/adc_tmr_reg.sv
// Module: triplicated register with bitwise majority vote.
// Holds NCOPY=3 copies of a W-bit value. Every copy loads the same next
// value d. When its upset bit is high, that copy loads the inverse of d,
// which models a single-event upset. q is the bitwise majority of the
// copies. disagree is high whenever any two copies differ.
// Assumes the caller feeds the next value from the voted q, so a bad copy
// is repaired on the edge after it is noticed.
module adc_tmr_reg
    import adc_regbank_pkg::*;
#(
    parameter int W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     d,
    input  logic [NCOPY-1:0] upset,
    output logic [W-1:0]     q,
    output logic             disagree
);

    logic [W-1:0] copy_q [0:NCOPY-1];

    generate
        for (genvar k = 0; k < NCOPY; k++) begin : g_copy
            // Load one copy, with the optional injected inversion
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    copy_q[k] <= '0;
                end else begin
                    copy_q[k] <= d ^ {W{upset[k]}};
                end
            end
        end

        for (genvar b = 0; b < W; b++) begin : g_vote
            // Majority of the three copies, one bit at a time
            assign q[b] = (copy_q[0][b] & copy_q[1][b])
                        | (copy_q[0][b] & copy_q[2][b])
                        | (copy_q[1][b] & copy_q[2][b]);
        end
    endgenerate

    // Any copy that differs from copy 0 counts as a disagreement
    always_comb begin
        disagree = 1'b0;
        for (int k = 1; k < NCOPY; k++) begin
            disagree = disagree | (|(copy_q[k] ^ copy_q[0]));
        end
    end

endmodule

// File: rtl/adc_ctrl_next.sv
// Module: next-state logic for the voted control state.
// Works out the next control value from the voted current value, a write
// to the control register, the converter done pulse and the copy
// disagreement. Also works out whether a start fires and whether a
// sample is captured.
// Order of precedence: soft reset, then the rest. A start is taken only
// while idle. A done pulse is taken only while busy.
module adc_ctrl_next
    import adc_regbank_pkg::*;
(
    input  ctrl_t             cur,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic              disagree,
    output ctrl_t             nxt,
    output logic              fire,
    output logic              capture,
    output logic              soft_rst
);

    // Decode the soft-reset request from a control write
    always_comb begin
        soft_rst = wr_ctrl & wdata[B_SRST];
    end

    // Next control state, start request and sample capture
    always_comb begin
        nxt     = cur;
        fire    = 1'b0;
        capture = 1'b0;
        if (soft_rst) begin
            nxt = '0;
        end else begin
            if (disagree) begin
                nxt.err = 1'b1;
            end
            if (wr_ctrl) begin
                nxt.chan = wdata[CHAN_W-1:0];
                nxt.mode = wdata[B_MODE];
            end
            if (wr_ctrl && wdata[B_START] && !cur.busy) begin
                nxt.busy = 1'b1;
                fire     = 1'b1;
            end else if (cur.busy && done) begin
                nxt.busy = 1'b0;
                capture  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_read_mux.sv
// Module: combinational read-back multiplexer.
// Forms the byte returned for each address from the voted control state,
// the stored result and the fixed serial number. Reserved addresses
// return zero. The self-clearing control bits always read back as zero.
module adc_read_mux
    import adc_regbank_pkg::*;
#(
    parameter logic [ID_W-1:0] SERIAL_ID = 24'h5A3C96
) (
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_t             cur,
    input  logic [RES_W-1:0]  result,
    output logic [DATA_W-1:0] rdata
);

    // Pick the byte for the addressed register
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[CHAN_W-1:0] = cur.chan;
                rdata[B_MODE]     = cur.mode;
            end
            A_STAT: begin
                rdata[RES_HI_W-1:0] = result[RES_W-1:DATA_W];
                rdata[B_ERR]        = cur.err;
                rdata[B_IDLE]       = ~cur.busy;
            end
            A_RESLO: rdata = result[DATA_W-1:0];
            A_ID0:   rdata = SERIAL_ID[DATA_W-1:0];
            A_ID1:   rdata = SERIAL_ID[2*DATA_W-1:DATA_W];
            A_ID2:   rdata = SERIAL_ID[3*DATA_W-1:2*DATA_W];
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/adc_regbank.sv
// Module: top of the monitor ADC control register bank.
// Connects the register port, the triplicated control state, the result
// store and the converter handshake. The start pulse is registered and
// lasts exactly one cycle. The result is not triplicated: both bytes load
// on the same edge, so a read of the high and low bytes gives one sample.
// Assumes adc_result is valid during the cycle in which adc_done is high.
module adc_regbank
    import adc_regbank_pkg::*;
#(
    parameter logic [ID_W-1:0] SERIAL_ID = 24'h5A3C96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              adc_start,
    output logic [CHAN_W-1:0] adc_chan,
    output logic              adc_mode,
    input  logic              adc_done,
    input  logic [RES_W-1:0]  adc_result,
    input  logic [NCOPY-1:0]  upset
);

    ctrl_t            state_v;
    ctrl_t            state_d;
    logic             disagree;
    logic             wr_ctrl;
    logic             fire;
    logic             capture;
    logic             soft_rst;
    logic [RES_W-1:0] result_q;
    logic             start_q;
    logic             busy_v;
    logic             err_v;

    // Decode a write to the control register
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    end

    adc_ctrl_next u_next (
        .cur      (state_v),
        .wr_ctrl  (wr_ctrl),
        .wdata    (reg_wdata),
        .done     (adc_done),
        .disagree (disagree),
        .nxt      (state_d),
        .fire     (fire),
        .capture  (capture),
        .soft_rst (soft_rst)
    );

    adc_tmr_reg #(
        .W (CTRL_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .d        (state_d),
        .upset    (upset),
        .q        (state_v),
        .disagree (disagree)
    );

    // Store the 12-bit sample when an acquisition finishes
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            result_q <= '0;
        end else if (capture) begin
            result_q <= adc_result;
        end
    end

    // Register the one-cycle converter start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else begin
            start_q <= fire;
        end
    end

    adc_read_mux #(
        .SERIAL_ID (SERIAL_ID)
    ) u_rmux (
        .addr   (reg_addr),
        .cur    (state_v),
        .result (result_q),
        .rdata  (reg_rdata)
    );

    // Drive the converter-side outputs from the voted state
    always_comb begin
        adc_start = start_q;
        adc_chan  = state_v.chan;
        adc_mode  = state_v.mode;
        busy_v    = state_v.busy;
        err_v     = state_v.err;
    end

endmodule

// File: rtl/adc_regbank_chk.sv
// Module: assertion checker for adc_regbank, attached with bind.
// Watches the register port, the converter handshake and the voted
// busy and error flags. Makes no change to the design.
module adc_regbank_chk
    import adc_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              adc_start,
    input logic              adc_done,
    input logic              busy_v,
    input logic              err_v,
    input logic              disagree
);

    logic srst_req;
    logic start_req;

    // Decode the host's soft-reset and start requests from the port
    always_comb begin
        srst_req  = reg_wr && (reg_addr == A_CTRL) && reg_wdata[B_SRST];
        start_req = reg_wr && (reg_addr == A_CTRL) && reg_wdata[B_START]
                    && !reg_wdata[B_SRST];
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R3
    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> $past(start_req)); // R3
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> busy_v); // R3
    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> !$past(busy_v)); // R4
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_v && adc_done) |=> !busy_v); // R5
    AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> (!busy_v && !err_v && !adc_start)); // R6
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_RSV0 || reg_addr == A_RSV1) |-> (reg_rdata == '0)); // R8
    AST_DISAGREE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (disagree && !srst_req) |=> err_v); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_v && !srst_req) |=> err_v); // R10

endmodule

bind adc_regbank adc_regbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .adc_start (adc_start),
    .adc_done  (adc_done),
    .busy_v    (busy_v),
    .err_v     (err_v),
    .disagree  (disagree)
);

// File: tb/adc_regbank_test.sv
// Bench for adc_regbank: a table of register vectors walked by one loop,
// then directed tests of the start/done handshake, soft reset and upsets.
// Inputs change on the falling edge; outputs are sampled on the falling edge.
module adc_regbank_test;

    localparam logic [23:0] SERIAL = 24'h5A3C96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        adc_start;
    logic [2:0]  adc_chan;
    logic        adc_mode;
    logic        adc_done = 1'b0;
    logic [11:0] adc_result = '0;
    logic [2:0]  upset = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc_regbank #(.SERIAL_ID(SERIAL)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .adc_start  (adc_start),
        .adc_chan   (adc_chan),
        .adc_mode   (adc_mode),
        .adc_done   (adc_done),
        .adc_result (adc_result),
        .upset      (upset)
    );

    // Vector fields: [19] write, [18:16] addr, [15:8] wdata, [7:0] expected read
    localparam int NVEC = 12;
    localparam logic [19:0] VEC [0:NVEC-1] = '{
        {1'b1, 3'd0, 8'h05, 8'h05},   // R2 channel 5
        {1'b1, 3'd0, 8'h0B, 8'h0B},   // R2 channel 3 with mode
        {1'b1, 3'd0, 8'h37, 8'h07},   // R2 upper bits read as zero
        {1'b0, 3'd5, 8'h00, 8'h96},   // R7 serial low byte
        {1'b0, 3'd6, 8'h00, 8'h3C},   // R7 serial middle byte
        {1'b0, 3'd7, 8'h00, 8'h5A},   // R7 serial high byte
        {1'b1, 3'd2, 8'hFF, 8'h00},   // R8 reserved address 2
        {1'b0, 3'd0, 8'h00, 8'h07},   // R8 control untouched
        {1'b1, 3'd4, 8'hFF, 8'h00},   // R8 reserved address 4
        {1'b0, 3'd0, 8'h00, 8'h07},   // R8 control untouched
        {1'b0, 3'd1, 8'h00, 8'h80},   // R8 status untouched
        {1'b0, 3'd3, 8'h00, 8'h00}    // R8 low result untouched
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic done_pulse(input logic [11:0] val);
        @(negedge clk);
        adc_done   = 1'b1;
        adc_result = val;
        @(negedge clk);
        adc_done   = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 8'h00);
        rd(3'd1, v); check("R1 status", v, 8'h80);
        rd(3'd3, v); check("R1 low", v, 8'h00);
        check("R1 start", {7'd0, adc_start}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
            rd(VEC[i][18:16], v);
            check($sformatf("vector %0d", i), v, VEC[i][7:0]);
        end
        check("R2 chan pins", {5'd0, adc_chan}, 8'h07);
        check("R2 mode pin", {7'd0, adc_mode}, 8'h00);

        // R3 start while idle
        wr(3'd0, 8'h8A);
        check("R3 start pulse", {7'd0, adc_start}, 8'h01);
        check("R2 chan on start", {4'd0, adc_mode, adc_chan}, 8'h0A);
        rd(3'd1, v); check("R3 idle low", v, 8'h00);
        rd(3'd0, v); check("R3 start bit reads zero", v, 8'h0A);
        @(negedge clk);
        check("R3 pulse one cycle", {7'd0, adc_start}, 8'h00);

        // R4 start while busy
        wr(3'd0, 8'h8A);
        check("R4 no pulse when busy", {7'd0, adc_start}, 8'h00);

        // R5 done completes acquisition
        done_pulse(12'hABC);
        rd(3'd1, v); check("R5 status high", v, 8'h8A);
        rd(3'd3, v); check("R5 low byte", v, 8'hBC);
        done_pulse(12'h123);
        rd(3'd1, v); check("R5 done while idle", v, 8'h8A);
        rd(3'd3, v); check("R5 low kept", v, 8'hBC);

        // R6 soft reset with start bit set
        wr(3'd0, 8'h8D);
        check("R3 second start", {7'd0, adc_start}, 8'h01);
        wr(3'd0, 8'hC5);
        check("R6 start ignored", {7'd0, adc_start}, 8'h00);
        rd(3'd0, v); check("R6 ctrl cleared", v, 8'h00);
        rd(3'd1, v); check("R6 status cleared", v, 8'h80);
        rd(3'd3, v); check("R6 low cleared", v, 8'h00);

        // R9 single-copy upset
        wr(3'd0, 8'h06);
        @(negedge clk); upset = 3'b010;
        @(negedge clk); upset = 3'b000;
        rd(3'd0, v); check("R9 voted ctrl kept", v, 8'h06);
        @(negedge clk);
        rd(3'd1, v); check("R9 error set", v, 8'hC0);
        wr(3'd0, 8'h03);
        rd(3'd1, v); check("R9 error sticky", v, 8'hC0);
        rd(3'd0, v); check("R9 ctrl after upset", v, 8'h03);

        // R10 clear by soft reset, then by rst_n
        wr(3'd0, 8'h40);
        rd(3'd1, v); check("R10 soft reset clears", v, 8'h80);
        @(negedge clk); upset = 3'b100;
        @(negedge clk); upset = 3'b000;
        @(negedge clk);
        rd(3'd1, v); check("R9 error set again", v, 8'hC0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(3'd1, v); check("R10 rst_n clears", v, 8'h80);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule